// File: doc/BRIEF.md
# Erase Status Bit Generator

This block models, in synthesizable form, the status bits that a parallel NOR flash returns to the bus while a block erase or a chip erase is running. Decoded command strobes select blocks for erase, start a chip erase, suspend and resume the erase, and clear an error. The block tracks which of up to eight blocks are selected, runs a programmable pending window and a programmable erase duration, and on every bus read returns either a status byte or the array data supplied from outside. Which one it returns depends on the state and on the block of the read address.

The status byte carries four live bits: a toggle bit (bit 6) that flips on every status read while the erase is active, an error bit (bit 5), an erase-timer bit (bit 3) that is 0 while more blocks may still be added and 1 once erasing has begun, and an alternative toggle bit (bit 2) that flips only for reads from selected blocks or, after a failure, only for reads from failed blocks. The block index is the top three bits of the address.

The controller has five states. READ is normal read mode. READ goes to PEND on a block selection, or straight to ERASE on a chip erase. PEND re-enters itself on each further selection, which restarts the window, and goes to ERASE when the window runs out. ERASE goes to SUSP on suspend, to FAIL when the duration runs out with any failed block, and to READ when it runs out cleanly. SUSP returns to ERASE on resume. FAIL returns to READ on an error clear.

Top module: `erase_status_gen`

## Requirements
- R1: After reset the block is in read mode: `rd_is_status_o` is 0 and `rd_data_o` is 0 until the first read.
- R2: In read mode every read returns `array_data_i` one cycle later with `rd_is_status_o` low.
- R3: A block-erase strobe in read mode enters the pending window. Status reads in the first `pend_cycles_i`+1 cycles after the strobe edge return bit 3 = 0. Reads after that return bit 3 = 1.
- R4: A block-erase strobe during the pending window adds its block to the selection and restarts the window from that edge.
- R5: Erasing lasts `erase_cycles_i`+1 cycles. If no block failed, reads after that return array data.
- R6: Bit 6 of the status byte flips after each status read in the pending, erase and failed states. It holds during suspend and is 0 after reset.
- R7: Bit 2 flips after each status read whose block is selected, in the pending, erase and suspend states. Reads of other blocks leave it unchanged. It is 0 after reset.
- R8: A suspend strobe during erase freezes the erase count. Reads of selected blocks return status with bit 3 = 1. Reads of other blocks return array data. A resume strobe continues the erase with the remaining count.
- R9: A chip-erase strobe in read mode selects all blocks and starts erasing at once, with no pending window.
- R10: `fail_inject_i` is sampled when erasing starts and is restricted to the selected blocks. If any block failed, the end of erase enters a state where all reads return status with bit 5 = 1 and bit 3 = 1, and bit 2 flips only for reads of failed blocks. A clear-error strobe returns the block to read mode.
- R11: Status bits 7, 4, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_cycles_i | input | CNT_W | Length of the pending window, minus one |
| erase_cycles_i | input | CNT_W | Erase duration, minus one |
| blk_erase_stb_i | input | 1 | Select the block of `addr_i` for erase |
| chip_erase_stb_i | input | 1 | Start a chip erase |
| suspend_stb_i | input | 1 | Suspend a running erase |
| resume_stb_i | input | 1 | Resume a suspended erase |
| clear_err_stb_i | input | 1 | Leave the failed state |
| fail_inject_i | input | NBLK | Blocks that will fail the erase |
| rd_stb_i | input | 1 | Bus read strobe |
| addr_i | input | ADDR_W | Read or selection address; the top bits give the block |
| array_data_i | input | DATA_W | Array contents at `addr_i` |
| rd_data_o | output | DATA_W | Registered read data |
| rd_is_status_o | output | 1 | High when `rd_data_o` holds a status byte |

## Verification
The hardest situation to reach is a suspend that lands inside the erase with a known remaining count, followed by resume. The exact cycle on which the device returns to read data then depends on the frozen count. The stimulus reaches it by issuing two selections, so that the window restarts, and counting every edge from the second strobe. It places the suspend on a known edge of the erase and reads selected and unselected blocks while suspended. After resume it reads every cycle until the block returns to data. Failure is reached by sweeping reads over all eight blocks after an erase with injected faults, so that every failed and passing block is read in the failed state.

// File: rtl/esg_pkg.sv
package esg_pkg;
    typedef enum logic [2:0] {
        ST_READ,
        ST_PEND,
        ST_ERASE,
        ST_SUSP,
        ST_FAIL
    } esg_state_e;

    localparam int SB_ALT   = 2;
    localparam int SB_TIMER = 3;
    localparam int SB_ERR   = 5;
    localparam int SB_TOG   = 6;
endpackage

// File: rtl/esg_cycle_timer.sv
module esg_cycle_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (load_i)                 cnt_q <= load_val_i;
        else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R5: the controller never asks for a step below zero
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/esg_blk_tracker.sv
module esg_blk_tracker #(
    parameter int NBLK = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    add_i,
    input  logic [$clog2(NBLK)-1:0] add_blk_i,
    input  logic                    all_i,
    input  logic                    latch_fail_i,
    input  logic [NBLK-1:0]         fail_inject_i,
    input  logic                    clear_i,
    output logic [NBLK-1:0]         sel_o,
    output logic [NBLK-1:0]         fail_o
);
    localparam int BLK_W = $clog2(NBLK);

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        logic s_q;
        logic f_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       s_q <= 1'b0;
            else if (clear_i) s_q <= 1'b0;
            else if (all_i || (add_i && add_blk_i == BLK_W'(g))) s_q <= 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            f_q <= 1'b0;
            else if (clear_i)      f_q <= 1'b0;
            else if (latch_fail_i) f_q <= fail_inject_i[g] & (all_i | s_q);
        end
        assign sel_o[g]  = s_q;
        assign fail_o[g] = f_q;
    end

    // R4: without a clear the selection only grows
    p_mask_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((sel_o & $past(sel_o)) == $past(sel_o)));
endmodule

// File: rtl/esg_read_port.sv
module esg_read_port
    import esg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NBLK   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_i,
    input  logic [$clog2(NBLK)-1:0] rd_blk_i,
    input  esg_state_e              state_i,
    input  logic [NBLK-1:0]         sel_i,
    input  logic [NBLK-1:0]         fail_i,
    input  logic [DATA_W-1:0]       array_i,
    output logic [DATA_W-1:0]       data_o,
    output logic                    status_o
);
    logic              tog_q, alt_q;
    logic              give_status, alt_step, tog_step, timer_bit, err_bit;
    logic              in_sel, in_fail;
    logic [DATA_W-1:0] stat_word;

    assign in_sel  = sel_i[rd_blk_i];
    assign in_fail = fail_i[rd_blk_i];

    always_comb begin
        give_status = 1'b0;
        alt_step    = 1'b0;
        tog_step    = 1'b0;
        timer_bit   = 1'b0;
        err_bit     = 1'b0;
        unique case (state_i)
            ST_READ: ;
            ST_PEND: begin
                give_status = 1'b1;
                alt_step    = in_sel;
                tog_step    = 1'b1;
            end
            ST_ERASE: begin
                give_status = 1'b1;
                alt_step    = in_sel;
                tog_step    = 1'b1;
                timer_bit   = 1'b1;
            end
            ST_SUSP: begin
                give_status = in_sel;
                alt_step    = in_sel;
                timer_bit   = 1'b1;
            end
            ST_FAIL: begin
                give_status = 1'b1;
                alt_step    = in_fail;
                tog_step    = 1'b1;
                timer_bit   = 1'b1;
                err_bit     = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        stat_word           = '0;
        stat_word[SB_TOG]   = tog_q;
        stat_word[SB_ERR]   = err_bit;
        stat_word[SB_TIMER] = timer_bit;
        stat_word[SB_ALT]   = alt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o   <= '0;
            status_o <= 1'b0;
            tog_q    <= 1'b0;
            alt_q    <= 1'b0;
        end else if (rd_i) begin
            data_o   <= give_status ? stat_word : array_i;
            status_o <= give_status;
            if (tog_step) tog_q <= ~tog_q;
            if (alt_step) alt_q <= ~alt_q;
        end
    end

    p_idle_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && state_i == ST_READ) |=> (!status_o && data_o == $past(array_i)));

    p_pend_timer_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && state_i == ST_PEND) |=> (status_o && !data_o[SB_TIMER]));

    p_susp_outside_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && state_i == ST_SUSP && !sel_i[rd_blk_i]) |=> (!status_o && data_o == $past(array_i)));

    p_failed_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && state_i == ST_FAIL) |=> (status_o && data_o[SB_ERR] && data_o[SB_TIMER]));

    p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        status_o |-> (!data_o[7] && !data_o[4] && data_o[1:0] == 2'b00));
endmodule

// File: rtl/erase_status_gen.sv
module erase_status_gen
    import esg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBLK   = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  pend_cycles_i,
    input  logic [CNT_W-1:0]  erase_cycles_i,
    input  logic              blk_erase_stb_i,
    input  logic              chip_erase_stb_i,
    input  logic              suspend_stb_i,
    input  logic              resume_stb_i,
    input  logic              clear_err_stb_i,
    input  logic [NBLK-1:0]   fail_inject_i,
    input  logic              rd_stb_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_is_status_o
);
    localparam int BLK_W = $clog2(NBLK);

    esg_state_e       state_q, state_d;
    logic [BLK_W-1:0] blk;
    logic             tmr_load, tmr_dec, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic             trk_add, trk_all, trk_latch, trk_clear;
    logic [NBLK-1:0]  sel_mask, fail_mask;

    assign blk = addr_i[ADDR_W-1 -: BLK_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READ;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READ:  if (chip_erase_stb_i)     state_d = ST_ERASE;
                      else if (blk_erase_stb_i) state_d = ST_PEND;
            ST_PEND:  if (!blk_erase_stb_i && tmr_zero) state_d = ST_ERASE;
            ST_ERASE: if (suspend_stb_i)        state_d = ST_SUSP;
                      else if (tmr_zero)        state_d = (|fail_mask) ? ST_FAIL : ST_READ;
            ST_SUSP:  if (resume_stb_i)         state_d = ST_ERASE;
            ST_FAIL:  if (clear_err_stb_i)      state_d = ST_READ;
            default:                            state_d = ST_READ;
        endcase
    end

    always_comb begin
        tmr_load  = 1'b0;
        tmr_val   = pend_cycles_i;
        tmr_dec   = 1'b0;
        trk_add   = 1'b0;
        trk_all   = 1'b0;
        trk_latch = 1'b0;
        trk_clear = 1'b0;
        unique case (state_q)
            ST_READ: begin
                if (chip_erase_stb_i) begin
                    trk_all   = 1'b1;
                    trk_latch = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = erase_cycles_i;
                end else if (blk_erase_stb_i) begin
                    trk_add  = 1'b1;
                    tmr_load = 1'b1;
                end
            end
            ST_PEND: begin
                if (blk_erase_stb_i) begin
                    trk_add  = 1'b1;
                    tmr_load = 1'b1;
                end else if (tmr_zero) begin
                    trk_latch = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = erase_cycles_i;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_ERASE: begin
                if (!suspend_stb_i) begin
                    if (tmr_zero) trk_clear = ~(|fail_mask);
                    else          tmr_dec   = 1'b1;
                end
            end
            ST_SUSP: ;
            ST_FAIL:  trk_clear = clear_err_stb_i;
            default:  trk_clear = 1'b1;
        endcase
    end

    esg_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .dec_i      (tmr_dec),
        .zero_o     (tmr_zero)
    );

    esg_blk_tracker #(.NBLK(NBLK)) u_tracker (
        .clk           (clk),
        .rst_n         (rst_n),
        .add_i         (trk_add),
        .add_blk_i     (blk),
        .all_i         (trk_all),
        .latch_fail_i  (trk_latch),
        .fail_inject_i (fail_inject_i),
        .clear_i       (trk_clear),
        .sel_o         (sel_mask),
        .fail_o        (fail_mask)
    );

    esg_read_port #(.DATA_W(DATA_W), .NBLK(NBLK)) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (rd_stb_i),
        .rd_blk_i (blk),
        .state_i  (state_q),
        .sel_i    (sel_mask),
        .fail_i   (fail_mask),
        .array_i  (array_data_i),
        .data_o   (rd_data_o),
        .status_o (rd_is_status_o)
    );

    p_susp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP && !resume_stb_i) |=> (state_q == ST_SUSP));

    p_chip_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && chip_erase_stb_i) |=> ((&sel_mask) && state_q == ST_ERASE));

    p_clean_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE && tmr_zero && !suspend_stb_i && fail_mask == '0)
            |=> (state_q == ST_READ && sel_mask == '0));

    p_fail_in_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE) |-> ((fail_mask & ~sel_mask) == '0));
endmodule

// File: tb/erase_status_gen_bench.sv
module erase_status_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pend_cycles = '0, erase_cycles = '0;
    logic        blk_stb = 0, chip_stb = 0, susp_stb = 0, res_stb = 0, clr_stb = 0, rd_stb = 0;
    logic [7:0]  fail_inj = '0;
    logic [7:0]  addr = '0, arr = '0;
    logic [7:0]  rd_data;
    logic        rd_is_status;

    int checks = 0, errors = 0;
    bit m_tog6 = 0, m_alt2 = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    erase_status_gen u_erase_status_gen (
        .clk              (clk),
        .rst_n            (rst_n),
        .pend_cycles_i    (pend_cycles),
        .erase_cycles_i   (erase_cycles),
        .blk_erase_stb_i  (blk_stb),
        .chip_erase_stb_i (chip_stb),
        .suspend_stb_i    (susp_stb),
        .resume_stb_i     (res_stb),
        .clear_err_stb_i  (clr_stb),
        .fail_inject_i    (fail_inj),
        .rd_stb_i         (rd_stb),
        .addr_i           (addr),
        .array_data_i     (arr),
        .rd_data_o        (rd_data),
        .rd_is_status_o   (rd_is_status)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // One bus read; expected byte built from the status layout in the requirements
    task automatic do_read(input logic [2:0] blk, input bit st, input bit b3, input bit b5,
                           input bit aq, input bit tf, input string tag);
        logic [7:0] exp;
        addr = {blk, 5'd9};
        arr  = {blk, 5'd9} ^ 8'hA5;
        if (st) exp = {1'b0, m_tog6, b5, 1'b0, b3, m_alt2, 2'b00};
        else    exp = arr;
        rd_stb = 1'b1;
        step();
        rd_stb = 1'b0;
        check(rd_is_status == st && rd_data == exp, tag, {rd_is_status, rd_data}, {st, exp});
        if (tf) m_tog6 = ~m_tog6;
        if (aq) m_alt2 = ~m_alt2;
    endtask

    task automatic select(input logic [2:0] blk);
        addr = {blk, 5'd0};
        blk_stb = 1'b1;
        step();
        blk_stb = 1'b0;
    endtask

    // Reads every cycle after the origin edge, block index walking through all blocks
    task automatic sweep(input int p, input int e, input logic [7:0] mask, input logic [7:0] failm, input int n);
        for (int d = 1; d <= n; d++) begin
            logic [2:0] b;
            b = 3'(d);
            if (d <= p + 1)          do_read(b, 1, 0, 0, mask[b], 1, "R3/R6/R7");
            else if (d <= p + 2 + e) do_read(b, 1, 1, 0, mask[b], 1, "R5/R6/R7");
            else if (failm != 0)     do_read(b, 1, 1, 1, failm[b], 1, "R10");
            else                     do_read(b, 0, 0, 0, 0, 0, "R5/R2");
        end
        if (failm != 0) begin
            clr_stb = 1'b1;
            step();
            clr_stb = 1'b0;
            do_read(3'd3, 0, 0, 0, 0, 0, "R10 clear");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rd_is_status == 0 && rd_data == 0, "R1", {rd_is_status, rd_data}, 9'h0);
        rst_n = 1'b1;
        step();
        check(rd_is_status == 0 && rd_data == 0, "R1", {rd_is_status, rd_data}, 9'h0);

        for (int b = 0; b < 8; b++) do_read(3'(b), 0, 0, 0, 0, 0, "R2");

        // Single-block erases over a grid of window and duration lengths
        for (int p = 0; p < 4; p++) begin
            for (int e = 0; e < 6; e += 2) begin
                pend_cycles  = 12'(p);
                erase_cycles = 12'(e);
                select(3'(p + e));
                sweep(p, e, 8'h1 << ((p + e) % 8), 8'h0, p + e + 5);
            end
        end

        // R4: a second selection in the window adds a block and restarts it
        pend_cycles = 12'd3; erase_cycles = 12'd2;
        select(3'd1);
        step();
        select(3'd4);
        sweep(3, 2, 8'h12, 8'h0, 10);

        // R10: failure restricted to selected blocks (7 is not selected)
        fail_inj = 8'hA0;
        pend_cycles = 12'd1; erase_cycles = 12'd3;
        select(3'd2);
        select(3'd5);
        sweep(1, 3, 8'h24, 8'h20, 16);
        fail_inj = 8'h00;

        // R9: chip erase, clean, then with two failed blocks
        erase_cycles = 12'd4;
        chip_stb = 1'b1; step(); chip_stb = 1'b0;
        sweep(-1, 4, 8'hFF, 8'h0, 8);
        fail_inj = 8'h42;
        chip_stb = 1'b1; step(); chip_stb = 1'b0;
        sweep(-1, 4, 8'hFF, 8'h42, 16);
        fail_inj = 8'h00;

        // R8: suspend on a known edge of the erase, then resume
        pend_cycles = 12'd1; erase_cycles = 12'd6;
        select(3'd2);
        select(3'd5);
        do_read(3'd2, 1, 0, 0, 1, 1, "R3");
        do_read(3'd0, 1, 0, 0, 0, 1, "R3");
        do_read(3'd5, 1, 1, 0, 1, 1, "R5");
        susp_stb = 1'b1; step(); susp_stb = 1'b0;
        do_read(3'd2, 1, 1, 0, 1, 0, "R8/R7");
        do_read(3'd3, 0, 0, 0, 0, 0, "R8");
        do_read(3'd5, 1, 1, 0, 1, 0, "R8/R6");
        repeat (5) step();
        do_read(3'd0, 0, 0, 0, 0, 0, "R8");
        res_stb = 1'b1; step(); res_stb = 1'b0;
        for (int k = 1; k <= 6; k++) do_read(3'd5, 1, 1, 0, 1, 1, "R8 resume");
        do_read(3'd5, 0, 0, 0, 0, 0, "R8 done");
        do_read(3'd6, 0, 0, 0, 0, 0, "R11/R2");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule